// File: doc/BRIEF.md
# Composite-Field GF(2^8) Inverter

This block returns the multiplicative inverse of a byte in the AES field GF(2^8), reduced by x^8+x^4+x^3+x+1, without a 256-entry table. The byte is first carried by a fixed 8x8 bit matrix into a tower representation GF(((2^2)^2)^2): an upper and a lower GF(2^4) half. The inverse is then formed there with nothing wider than 4-bit arithmetic, and a second fixed matrix carries the result back to the polynomial basis. Zero has no inverse and is passed through as zero.

Inside the tower, the element A = A_H·z + A_L is raised to the 17th power. That power is the norm A_H^2·λ + A_H·A_L + A_L^2, and it always lands in GF(2^4). The norm is inverted in GF(2^4) by the same trick one level lower, ending in a GF(2^2) square. It is then multiplied by A^16 = A_H·z + (A_H + A_L), the conjugate of A. The three tower levels use x^2+x+1 over GF(2), y^2+y+φ with φ = x (code 2'b10), and z^2+z+λ with λ = (x+1)·y (code 4'b1100). The two basis matrices are derived when the design is elaborated: a search finds a tower root of the AES polynomial, and the columns of the forward matrix are that root's powers.

A parameter STAGES (0 to 3) places register cuts after the forward map, after the GF(2^4) inversion and after the final multiply. A valid bit travels beside the data. Each cut loads only when its incoming valid bit is high, so bubbles leave the output byte unchanged. The block has no state machine: its only states are the contents of the cuts, and the only transition is a load on a valid cycle.

Top module: `gf256_tower_inv`

## Requirements
- R1: For every nonzero input x, the output y satisfies x·y = 1 in GF(2^8) with reduction polynomial 0x11B.
- R2: An input of 0x00 gives an output of 0x00.
- R3: Known pairs hold: 0x01→0x01, 0x02→0x8D, 0x03→0xF6, 0x53→0xCA, 0xCA→0x53, 0xFF→0x1C.
- R4: out_valid equals in_valid delayed by exactly STAGES clock cycles, and out_byte at that time is the inverse of the byte presented with it.
- R5: While rst_n is low, out_valid is 0 and (for STAGES ≥ 1) out_byte is 0x00.
- R6: Feeding an output back as an input returns the original byte.
- R7: A new byte is accepted every cycle, and results leave in input order with no gaps.
- R8: For STAGES ≥ 1, cycles with in_valid low do not change out_byte: it keeps the last valid result whatever in_byte carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_byte carries an operand this cycle |
| in_byte | input | 8 | Operand in AES polynomial basis |
| out_valid | output | 1 | out_byte carries a result this cycle |
| out_byte | output | 8 | Multiplicative inverse of the operand, AES basis |

## Verification
Two things can happen in the same cycle: an operand is admitted at the first cut while the last cut is skipping a bubble, and the output must hold. The bench provokes this by streaming all 256 bytes back to back, then sending a single operand followed by invalid cycles in which in_byte changes. It judges each result against an inverse found by brute-force field multiplication in the bench, and checks that out_byte keeps its value while out_valid is low.

// File: rtl/tfinv_pkg.sv
package tfinv_pkg;

    localparam logic [1:0] PHI    = 2'b10;
    localparam logic [3:0] LAMBDA = 4'b1100;

    function automatic logic [1:0] gf4_mul(input logic [1:0] a, input logic [1:0] b);
        logic hh;
        hh = a[1] & b[1];
        return {hh ^ (a[1] & b[0]) ^ (a[0] & b[1]), hh ^ (a[0] & b[0])};
    endfunction

    function automatic logic [1:0] gf4_sq(input logic [1:0] a);
        return {a[1], a[1] ^ a[0]};
    endfunction

    function automatic logic [3:0] gf16_mul(input logic [3:0] a, input logic [3:0] b);
        logic [1:0] hh;
        hh = gf4_mul(a[3:2], b[3:2]);
        return {hh ^ gf4_mul(a[3:2], b[1:0]) ^ gf4_mul(a[1:0], b[3:2]),
                gf4_mul(hh, PHI) ^ gf4_mul(a[1:0], b[1:0])};
    endfunction

    function automatic logic [3:0] gf16_sq(input logic [3:0] a);
        return gf16_mul(a, a);
    endfunction

    function automatic logic [7:0] tower_mul(input logic [7:0] a, input logic [7:0] b);
        logic [3:0] hh;
        hh = gf16_mul(a[7:4], b[7:4]);
        return {hh ^ gf16_mul(a[7:4], b[3:0]) ^ gf16_mul(a[3:0], b[7:4]),
                gf16_mul(hh, LAMBDA) ^ gf16_mul(a[3:0], b[3:0])};
    endfunction

    // Column i of a matrix sits at bits [8i+7:8i]: image of input bit i.
    function automatic logic [7:0] apply_map(input logic [63:0] m, input logic [7:0] x);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 0; i < 8; i++)
            if (x[i]) r = r ^ m[8*i +: 8];
        return r;
    endfunction

    function automatic logic [7:0] aes_poly_at(input logic [7:0] b);
        logic [7:0] p2, p3, p4, p8;
        p2 = tower_mul(b, b);
        p3 = tower_mul(p2, b);
        p4 = tower_mul(p2, p2);
        p8 = tower_mul(p4, p4);
        return p8 ^ p4 ^ p3 ^ b ^ 8'h01;
    endfunction

    function automatic logic [63:0] build_fwd();
        logic [7:0]  root;
        logic [7:0]  pw;
        logic [63:0] m;
        logic        found;
        root  = 8'h00;
        found = 1'b0;
        for (int c = 2; c < 256; c++) begin
            if (!found && aes_poly_at(8'(c)) == 8'h00) begin
                root  = 8'(c);
                found = 1'b1;
            end
        end
        m  = 64'd0;
        pw = 8'h01;
        for (int i = 0; i < 8; i++) begin
            m[8*i +: 8] = pw;
            pw = tower_mul(pw, root);
        end
        return m;
    endfunction

    function automatic logic [63:0] build_inv(input logic [63:0] fwd);
        logic [63:0] m;
        m = 64'd0;
        for (int j = 0; j < 8; j++)
            for (int x = 1; x < 256; x++)
                if (apply_map(fwd, 8'(x)) == (8'h01 << j))
                    m[8*j +: 8] = 8'(x);
        return m;
    endfunction

endpackage

// File: rtl/tfinv_map.sv
module tfinv_map #(
    parameter logic [63:0] MATRIX = 64'h8040201008040201
) (
    input  logic [7:0] src,
    output logic [7:0] dst
);
    logic [7:0] part [9];

    assign part[0] = 8'h00;
    for (genvar i = 0; i < 8; i++) begin : g_col
        assign part[i+1] = part[i] ^ (src[i] ? MATRIX[8*i +: 8] : 8'h00);
    end
    assign dst = part[8];
endmodule

// File: rtl/tfinv_norm.sv
module tfinv_norm (
    input  logic [7:0] elem,
    output logic [3:0] norm,
    output logic [7:0] conj
);
    import tfinv_pkg::*;

    logic [3:0] hi, lo;
    assign hi = elem[7:4];
    assign lo = elem[3:0];

    always_comb begin
        norm = gf16_mul(gf16_sq(hi), LAMBDA) ^ gf16_mul(hi, lo) ^ gf16_sq(lo);
        conj = {hi, hi ^ lo};
    end
endmodule

// File: rtl/tfinv_gf16_inv.sv
module tfinv_gf16_inv (
    input  logic [3:0] val,
    output logic [3:0] inv
);
    import tfinv_pkg::*;

    logic [1:0] bh, bl, sub_norm, sub_inv;
    assign bh = val[3:2];
    assign bl = val[1:0];

    always_comb begin
        sub_norm = gf4_mul(gf4_sq(bh), PHI) ^ gf4_mul(bh, bl) ^ gf4_sq(bl);
        sub_inv  = gf4_sq(sub_norm);
        inv      = {gf4_mul(bh, sub_inv), gf4_mul(bh ^ bl, sub_inv)};
    end
endmodule

// File: rtl/tfinv_stage_reg.sv
module tfinv_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         v_in,
    input  logic [W-1:0] d_in,
    output logic         v_out,
    output logic [W-1:0] d_out
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_out <= 1'b0;
            d_out <= '0;
        end else begin
            v_out <= v_in;
            if (v_in) d_out <= d_in;
        end
    end
endmodule

// File: rtl/gf256_tower_inv.sv
module gf256_tower_inv #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic [7:0] out_byte
);
    import tfinv_pkg::*;

    localparam logic [63:0] FWD_M = build_fwd();
    localparam logic [63:0] INV_M = build_inv(FWD_M);
    localparam int MID_W = 12;

    logic [7:0]       a_tow, s1_d;
    logic             s1_v, s2_v, s3_v;
    logic [3:0]       nrm, nrm_inv;
    logic [7:0]       conj;
    logic [MID_W-1:0] mid_in, s2_d;
    logic [7:0]       t_inv, s3_d;

    tfinv_map #(.MATRIX(FWD_M)) u_map_in (.src(in_byte), .dst(a_tow));

    if (STAGES >= 1) begin : g_cut1
        tfinv_stage_reg #(.W(8)) u_cut1 (
            .clk(clk), .rst_n(rst_n), .v_in(in_valid), .d_in(a_tow),
            .v_out(s1_v), .d_out(s1_d));
    end else begin : g_pass1
        assign s1_v = in_valid;
        assign s1_d = a_tow;
    end

    tfinv_norm     u_norm (.elem(s1_d), .norm(nrm), .conj(conj));
    tfinv_gf16_inv u_ninv (.val(nrm), .inv(nrm_inv));
    assign mid_in = {nrm_inv, conj};

    if (STAGES >= 2) begin : g_cut2
        tfinv_stage_reg #(.W(MID_W)) u_cut2 (
            .clk(clk), .rst_n(rst_n), .v_in(s1_v), .d_in(mid_in),
            .v_out(s2_v), .d_out(s2_d));
    end else begin : g_pass2
        assign s2_v = s1_v;
        assign s2_d = mid_in;
    end

    always_comb begin
        t_inv = {gf16_mul(s2_d[7:4], s2_d[11:8]), gf16_mul(s2_d[3:0], s2_d[11:8])};
    end

    if (STAGES >= 3) begin : g_cut3
        tfinv_stage_reg #(.W(8)) u_cut3 (
            .clk(clk), .rst_n(rst_n), .v_in(s2_v), .d_in(t_inv),
            .v_out(s3_v), .d_out(s3_d));
    end else begin : g_pass3
        assign s3_v = s2_v;
        assign s3_d = t_inv;
    end

    tfinv_map #(.MATRIX(INV_M)) u_map_out (.src(s3_d), .dst(out_byte));
    assign out_valid = s3_v;
endmodule

// File: rtl/gf256_tower_inv_chk.sv
module gf256_tower_inv_chk #(
    parameter int STAGES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       out_valid,
    input logic [7:0] out_byte
);
    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r, x;
        r = 8'h00;
        x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r = r ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
        end
        return r;
    endfunction

    logic       dly_v;
    logic [7:0] dly_b;

    if (STAGES == 0) begin : g_nodly
        assign dly_v = in_valid;
        assign dly_b = in_byte;
    end else begin : g_dly
        logic       hv [STAGES];
        logic [7:0] hb [STAGES];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int k = 0; k < STAGES; k++) begin
                    hv[k] <= 1'b0;
                    hb[k] <= 8'h00;
                end
            end else begin
                hv[0] <= in_valid;
                hb[0] <= in_byte;
                for (int k = 1; k < STAGES; k++) begin
                    hv[k] <= hv[k-1];
                    hb[k] <= hb[k-1];
                end
            end
        end
        assign dly_v = hv[STAGES-1];
        assign dly_b = hb[STAGES-1];
    end

    p_inverse_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && dly_b != 8'h00) |-> (fmul(dly_b, out_byte) == 8'h01));

    p_zero_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && dly_b == 8'h00) |-> (out_byte == 8'h00));

    p_valid_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == dly_v);

    if (STAGES >= 1) begin : g_hold
        p_bubble_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid |-> $stable(out_byte));
    end
endmodule

bind gf256_tower_inv gf256_tower_inv_chk #(.STAGES(STAGES)) u_chk (.*);

// File: tb/sim_gf256_tower_inv.sv
module sim_gf256_tower_inv;
    localparam int LAT = 2;
    localparam int NKNOWN = 7;
    localparam logic [15:0] KNOWN [NKNOWN] = '{
        16'h0101, 16'h028D, 16'h03F6, 16'h53CA, 16'hCA53, 16'hFF1C, 16'h0000
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid;
    logic [7:0] out_byte;
    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    gf256_tower_inv #(.STAGES(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_byte(out_byte));

    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r, x;
        r = 8'h00;
        x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r = r ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] ref_inv(input logic [7:0] a);
        logic [7:0] r;
        r = 8'h00;
        for (int y = 1; y < 256; y++)
            if (a != 8'h00 && ref_mul(a, 8'(y)) == 8'h01) r = 8'(y);
        return r;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [7:0] x, output logic [7:0] y);
        @(negedge clk);
        in_byte  = x;
        in_valid = 1'b1;
        for (int k = 1; k <= LAT; k++) begin
            @(negedge clk);
            if (k == 1) in_valid = 1'b0;
        end
        y = out_byte;
        chk("R4 valid with result", {7'd0, out_valid}, 8'h01);
    endtask

    initial begin
        #(10 * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] y, z;
        // R5: reset state
        repeat (3) @(negedge clk);
        chk("R5 out_valid in reset", {7'd0, out_valid}, 8'h00);
        chk("R5 out_byte in reset", out_byte, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 out_valid after reset", {7'd0, out_valid}, 8'h00);

        // R3 / R2: known-pair table
        for (int i = 0; i < NKNOWN; i++) begin
            run_one(KNOWN[i][15:8], y);
            chk(KNOWN[i][15:8] == 8'h00 ? "R2 zero" : "R3 known pair", y, KNOWN[i][7:0]);
        end

        // R1 / R7: back-to-back sweep of all bytes
        for (int i = 0; i < 256 + LAT; i++) begin
            @(negedge clk);
            if (i >= LAT) begin
                chk("R7 stream valid", {7'd0, out_valid}, 8'h01);
                chk("R1 inverse", out_byte, ref_inv(8'(i - LAT)));
            end
            if (i < 256) begin
                in_byte  = 8'(i);
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;

        // R6: involution
        for (int i = 0; i < 4; i++) begin
            logic [7:0] x;
            x = 8'(8'h17 + 8'h3D * i);
            run_one(x, y);
            run_one(y, z);
            chk("R6 involution", z, x);
        end

        // R4: single pulse timing
        @(negedge clk);
        in_byte  = 8'h09;
        in_valid = 1'b1;
        for (int k = 1; k <= LAT + 1; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            chk("R4 valid timing", {7'd0, out_valid}, (k == LAT) ? 8'h01 : 8'h00);
        end

        // R8: bubbles with changing in_byte leave out_byte unchanged
        run_one(8'h53, y);
        chk("R8 loaded", y, 8'hCA);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_byte  = 8'(8'h60 + k);
            in_valid = 1'b0;
            chk("R8 hold in bubble", out_byte, 8'hCA);
        end

        // R5: reset again mid-run
        @(negedge clk);
        in_byte  = 8'h44;
        in_valid = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        chk("R5 out_valid on reset", {7'd0, out_valid}, 8'h00);
        chk("R5 out_byte on reset", out_byte, 8'h00);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule